// File: doc/BRIEF.md
# Circular-Buffer Mersenne Twister Random Word Generator

This block produces a stream of 32-bit pseudo-random words from the MT19937 recurrence. Its period is 2^19937 − 1. The 624-word state is kept as a ring of registers that shifts by one word on each step. The newest word enters at the tail and the oldest word leaves at the head. Because of this, the three words the recurrence reads always sit at the same ring positions: the head, the one after it, and the one 397 places ahead. The recurrence is plain combinational logic between the ring's head and its tail, and no read or write address has to be generated.

A pulse on the seed-load input starts an expansion of a 32-bit seed into all 624 state words, one word per cycle. Once the ring is full, the block moves to its running state. From then on it delivers one tempered word per cycle through a valid/ready output register, and it holds completely still while the consumer holds ready low.

The controller has three states, each named below with the transitions that enter it:

- IDLE is entered from reset and waits for a seed.
- SEED is entered from any state on a seed-load pulse. It stays for 624 cycles, one per state word.
- RUN is entered from SEED after the last state word is written. It leaves only on a new seed-load pulse.

Top module: `mt_ring_rng`

## Requirements
- R1: While reset is high, and afterwards until the first seed load, `rnd_valid_o` is 0 and `rnd_o` is 0.
- R2: A seed load writes state word 0 = seed and word i = (1812433253 × (word(i−1) XOR (word(i−1) >> 30)) + i) mod 2^32, one word per cycle. `rnd_valid_o` stays 0 during this expansion and first rises exactly 625 clock edges after the edge that samples `seed_load_i`, counting that edge as the first.
- R3: Each new state word is word[397] XOR (y >> 1) XOR (y[0] ? 0x9908B0DF : 0), where y is bit 31 of the oldest word joined to bits 30..0 of the next word. The new word replaces the oldest word, and the sequence stays correct across any number of ring wraps.
- R4: Each emitted word is the new state word passed through these tempering steps in this order: y ^= y>>11; y ^= (y<<7) & 0x9D2C5680; y ^= (y<<15) & 0xEFC60000; y ^= y>>18.
- R5: After seed 5489, the first emitted word is 3499211612.
- R6: In RUN with `rnd_ready_i` held high, `rnd_valid_o` stays high and a fresh word appears on every clock cycle.
- R7: While `rnd_valid_o` is high and `rnd_ready_i` is low, `rnd_o` and `rnd_valid_o` hold their values and the state does not advance. The word after the stall is the next word of the sequence, with none skipped or repeated.
- R8: A seed load is accepted in any state, including during a stall and in the middle of an expansion. It drops `rnd_valid_o` at the next edge and restarts the expansion from the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_load_i | input | 1 | One-cycle request to restart from `seed_i` |
| seed_i | input | 32 | Seed value sampled with `seed_load_i` |
| rnd_ready_i | input | 1 | Consumer accepts `rnd_o` on this edge when valid |
| rnd_o | output | 32 | Tempered random word |
| rnd_valid_o | output | 1 | `rnd_o` holds a word not yet accepted |

## Verification
A seed load can arrive in the same cycle as an output stall, or in the same cycle as an ongoing expansion. In both cases the reload must win, and the held word must be dropped rather than delivered. The bench provokes the first case by holding ready low on a valid word and then pulsing seed-load. It provokes the second by reseeding 100 cycles into an expansion. Both are judged by the reload latency and by word-for-word agreement with an arithmetic software model reseeded at the same point. The stall case is also judged under several ready patterns, by requiring the held word to stay put and the next word to follow without a gap.

// File: rtl/mt_pkg.sv
package mt_pkg;

    localparam int          MT_WORD_W   = 32;
    localparam int          MT_RING_N   = 624;
    localparam int          MT_MID_M    = 397;
    localparam logic [31:0] MT_TWIST_A  = 32'h9908_B0DF;
    localparam logic [31:0] MT_INIT_F   = 32'd1812433253;
    localparam int          MT_TMP_U    = 11;
    localparam int          MT_TMP_S    = 7;
    localparam logic [31:0] MT_TMP_B    = 32'h9D2C_5680;
    localparam int          MT_TMP_T    = 15;
    localparam logic [31:0] MT_TMP_C    = 32'hEFC6_0000;
    localparam int          MT_TMP_L    = 18;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEED = 2'd1,
        ST_RUN  = 2'd2
    } mt_state_e;

endpackage

// File: rtl/mt_twist.sv
module mt_twist #(
    parameter int          W = 32,
    parameter logic [W-1:0] A = 32'h9908_B0DF
) (
    input  logic         head_msb,
    input  logic [W-2:0] next_lsbs,
    input  logic [W-1:0] mid_word,
    output logic [W-1:0] new_word
);
    logic [W-1:0] joined;
    logic [W-1:0] mixed;

    always_comb begin
        joined   = {head_msb, next_lsbs};
        mixed    = (joined >> 1) ^ (joined[0] ? A : '0);
        new_word = mid_word ^ mixed;
    end
endmodule

// File: rtl/mt_temper.sv
module mt_temper #(
    parameter int           W  = 32,
    parameter int           U  = 11,
    parameter int           S  = 7,
    parameter logic [W-1:0] B  = 32'h9D2C_5680,
    parameter int           T  = 15,
    parameter logic [W-1:0] C  = 32'hEFC6_0000,
    parameter int           L  = 18
) (
    input  logic [W-1:0] raw_word,
    output logic [W-1:0] out_word
);
    logic [W-1:0] s1, s2, s3;

    always_comb begin
        s1       = raw_word ^ (raw_word >> U);
        s2       = s1 ^ ((s1 << S) & B);
        s3       = s2 ^ ((s2 << T) & C);
        out_word = s3 ^ (s3 >> L);
    end
endmodule

// File: rtl/mt_seed_step.sv
module mt_seed_step #(
    parameter int           W     = 32,
    parameter int           IDX_W = 10,
    parameter logic [W-1:0] F     = 32'd1812433253
) (
    input  logic [W-1:0]     prev_word,
    input  logic [IDX_W-1:0] word_idx,
    output logic [W-1:0]     next_word
);
    logic [W-1:0] folded;

    always_comb begin
        folded    = prev_word ^ (prev_word >> (W - 2));
        next_word = F * folded + W'(word_idx);
    end
endmodule

// File: rtl/mt_ring_rng.sv
module mt_ring_rng
    import mt_pkg::*;
#(
    parameter int           WORD_W = MT_WORD_W,
    parameter int           RING_N = MT_RING_N,
    parameter int           MID_M  = MT_MID_M
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load_i,
    input  logic [WORD_W-1:0] seed_i,
    input  logic              rnd_ready_i,
    output logic [WORD_W-1:0] rnd_o,
    output logic              rnd_valid_o
);
    localparam int               IDX_W    = $clog2(RING_N);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(RING_N - 1);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

    mt_state_e         state_q, state_d;
    logic [WORD_W-1:0] ring_q [RING_N];
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] prev_q;
    logic [WORD_W-1:0] out_q;
    logic              vld_q;

    logic              shift_en;
    logic              fire;
    logic              seeding;
    logic [WORD_W-1:0] push_word;
    logic [WORD_W-1:0] twist_word;
    logic [WORD_W-1:0] seed_word;
    logic [WORD_W-1:0] tempered;

    // Recurrence taps at fixed ring positions: head, head+1, head+MID_M
    mt_twist #(.W(WORD_W), .A(WORD_W'(MT_TWIST_A))) u_twist (
        .head_msb (ring_q[0][WORD_W-1]),
        .next_lsbs(ring_q[1][WORD_W-2:0]),
        .mid_word (ring_q[MID_M]),
        .new_word (twist_word)
    );

    mt_temper #(
        .W(WORD_W), .U(MT_TMP_U), .S(MT_TMP_S), .B(WORD_W'(MT_TMP_B)),
        .T(MT_TMP_T), .C(WORD_W'(MT_TMP_C)), .L(MT_TMP_L)
    ) u_temper (
        .raw_word(twist_word),
        .out_word(tempered)
    );

    mt_seed_step #(.W(WORD_W), .IDX_W(IDX_W), .F(WORD_W'(MT_INIT_F))) u_seed (
        .prev_word(prev_q),
        .word_idx (idx_q),
        .next_word(seed_word)
    );

    // Next-state and control decode
    always_comb begin
        state_d   = state_q;
        shift_en  = 1'b0;
        fire      = 1'b0;
        seeding   = 1'b0;
        push_word = '0;
        if (seed_load_i) begin
            state_d   = ST_SEED;
            shift_en  = 1'b1;
            seeding   = 1'b1;
            push_word = seed_i;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_SEED: begin
                    shift_en  = 1'b1;
                    seeding   = 1'b1;
                    push_word = seed_word;
                    if (idx_q == IDX_LAST) state_d = ST_RUN;
                end
                ST_RUN: begin
                    fire      = !vld_q || rnd_ready_i;
                    shift_en  = fire;
                    push_word = twist_word;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Ring: every stage takes its successor, tail takes the pushed word
    generate
        for (genvar g = 0; g < RING_N; g++) begin : g_ring
            if (g == RING_N - 1) begin : g_tail
                always_ff @(posedge clk) begin
                    if (shift_en) ring_q[g] <= push_word;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (shift_en) ring_q[g] <= ring_q[g+1];
                end
            end
        end
    endgenerate

    // Seed expansion bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            prev_q <= '0;
        end else if (seeding) begin
            idx_q  <= seed_load_i ? IDX_ONE : idx_q + 1'b1;
            prev_q <= push_word;
        end
    end

    // Output register with valid/ready
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            vld_q <= 1'b0;
        end else if (seed_load_i) begin
            vld_q <= 1'b0;
        end else if (fire) begin
            out_q <= tempered;
            vld_q <= 1'b1;
        end
    end

    always_comb begin
        rnd_o       = out_q;
        rnd_valid_o = vld_q;
    end

endmodule

// File: rtl/mt_ring_rng_chk.sv
module mt_ring_rng_chk #(
    parameter int W = 32,
    parameter int N = 624
) (
    input logic         clk,
    input logic         rst,
    input logic         seed_load_i,
    input logic         rnd_ready_i,
    input logic [W-1:0] rnd_o,
    input logic         rnd_valid_o,
    input logic         in_run
);
    localparam int CW = $clog2(N + 2);
    localparam logic [CW-1:0] C_DONE = CW'(N + 1);

    logic [CW-1:0] since_load;

    always_ff @(posedge clk) begin
        if (rst)                                      since_load <= '0;
        else if (seed_load_i)                         since_load <= CW'(1);
        else if (since_load != '0 && since_load != C_DONE) since_load <= since_load + 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !rnd_valid_o && rnd_o == '0); // R1

    AST_VALID_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
        rnd_valid_o |-> in_run); // R2

    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (rst)
        (since_load != '0 && since_load != C_DONE) |-> !rnd_valid_o); // R2

    AST_SEED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(rnd_valid_o) |-> since_load == C_DONE); // R2

    AST_KEEP_FLOWING: assert property (@(posedge clk) disable iff (rst)
        in_run && rnd_valid_o && rnd_ready_i && !seed_load_i |=> rnd_valid_o); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        rnd_valid_o && !rnd_ready_i && !seed_load_i |=> rnd_valid_o && $stable(rnd_o)); // R7

    AST_RELOAD_DROP: assert property (@(posedge clk) disable iff (rst)
        seed_load_i |=> !rnd_valid_o); // R8

endmodule

bind mt_ring_rng mt_ring_rng_chk #(.W(WORD_W), .N(RING_N)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .seed_load_i(seed_load_i),
    .rnd_ready_i(rnd_ready_i),
    .rnd_o      (rnd_o),
    .rnd_valid_o(rnd_valid_o),
    .in_run     (state_q == mt_pkg::ST_RUN)
);

// File: tb/sim_mt_ring_rng.sv
`timescale 1ns/1ps
module sim_mt_ring_rng;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load_i = 1'b0;
    logic [31:0] seed_i = '0;
    logic        rnd_ready_i = 1'b0;
    logic [31:0] rnd_o;
    logic        rnd_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mt_ring_rng u0 (
        .clk(clk), .rst(rst), .seed_load_i(seed_load_i), .seed_i(seed_i),
        .rnd_ready_i(rnd_ready_i), .rnd_o(rnd_o), .rnd_valid_o(rnd_valid_o)
    );

    // Software model of the generator
    logic [31:0] mref [624];
    int          mpos;
    logic [31:0] lfsr = 32'hACE1_2345;

    function automatic void ref_seed(input logic [31:0] s);
        mref[0] = s;
        for (int i = 1; i < 624; i++)
            mref[i] = 32'(32'd1812433253 * (mref[i-1] ^ (mref[i-1] >> 30))) + 32'(i);
        mpos = 624;
    endfunction

    function automatic logic [31:0] ref_next();
        logic [31:0] y;
        if (mpos >= 624) begin
            for (int k = 0; k < 624; k++) begin
                y = {mref[k][31], mref[(k + 1) % 624][30:0]};
                mref[k] = mref[(k + 397) % 624] ^ (y >> 1) ^ (y[0] ? 32'h9908B0DF : 32'h0);
            end
            mpos = 0;
        end
        y = mref[mpos];
        mpos++;
        y = y ^ (y >> 11);
        y = y ^ ((y << 7) & 32'h9D2C5680);
        y = y ^ ((y << 15) & 32'hEFC60000);
        y = y ^ (y >> 18);
        return y;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse seed load and measure the cycles to first valid (R2, R8)
    task automatic load_seed(input logic [31:0] s, input bit measure);
        int k;
        @(negedge clk);
        seed_i = s;
        seed_load_i = 1'b1;
        @(negedge clk);
        seed_load_i = 1'b0;
        check(rnd_valid_o == 1'b0, "R8 valid dropped after reload", 32'(rnd_valid_o), 32'd0);
        ref_seed(s);
        if (measure) begin
            k = 1;
            while (!rnd_valid_o && k < 2000) begin
                @(negedge clk);
                k++;
            end
            check(k == 625, "R2 seed-to-valid latency", 32'(k), 32'd625);
        end
    endtask

    // Stream n words under a ready pattern, comparing every word (R3 R4 R6 R7)
    task automatic stream(input int n, input int mode);
        int got = 0;
        int cyc = 0;
        bit have = 0;
        bit stalled = 0;
        logic [31:0] exp = '0;
        logic [31:0] held = '0;
        bit r;
        while (got < n) begin
            if (rnd_valid_o) begin
                if (!have) begin
                    exp = ref_next();
                    have = 1;
                end
                check(rnd_o == exp, "R3 R4 word matches model", rnd_o, exp);
                if (stalled)
                    check(rnd_o == held, "R7 word held under stall", rnd_o, held);
            end else if (mode == 0 && got > 0) begin
                check(0, "R6 valid gap with ready high", 32'd0, 32'd1);
            end
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            unique case (mode)
                0: r = 1'b1;
                1: r = cyc[0];
                2: r = lfsr[3];
                default: r = (cyc % 16) < 4;
            endcase
            rnd_ready_i = r;
            stalled = rnd_valid_o && !r;
            held = rnd_o;
            if (rnd_valid_o && r) begin
                have = 0;
                got++;
            end
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] w0;
        rnd_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        check(rnd_valid_o == 1'b0, "R1 valid low in reset", 32'(rnd_valid_o), 32'd0);
        check(rnd_o == 32'd0, "R1 data zero in reset", rnd_o, 32'd0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        check(rnd_valid_o == 1'b0, "R1 idle without seed", 32'(rnd_valid_o), 32'd0);

        // Seed 5489: known first word, then long run through ring wraps
        load_seed(32'd5489, 1);
        rnd_ready_i = 1'b0;
        w0 = rnd_o;
        check(w0 == 32'd3499211612, "R5 first word for seed 5489", w0, 32'd3499211612);
        stream(1500, 0);
        stream(700, 2);

        // Reload while a word is stalled (R8)
        rnd_ready_i = 1'b0;
        @(negedge clk);
        check(rnd_valid_o == 1'b1, "R7 valid held under stall", 32'(rnd_valid_o), 32'd1);
        load_seed(32'd1, 1);
        stream(700, 1);

        // Reload in the middle of an expansion (R8)
        load_seed(32'hFFFF_FFFF, 0);
        repeat (100) @(negedge clk);
        check(rnd_valid_o == 1'b0, "R2 valid low during expansion", 32'(rnd_valid_o), 32'd0);
        load_seed(32'd0, 1);
        stream(1300, 3);

        load_seed(32'h1234_5678, 1);
        stream(650, 2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule